// File: doc/BRIEF.md
# Control-Store Loader with Half-Word Parity

This block sits between a host register interface and a small processor's instruction store. Software loads a program into the store. It first writes the index register with the programming-mode bit set and a start address. It then writes each 40-bit instruction as two words: the low 32 bits first, then a word that carries instruction bits 39:32 in its low byte. The write of that second word commits the instruction. The block appends two even-parity bits, one for each 20-bit half, and stores a 42-bit word. It then advances the index. When the index passes the last location it returns to zero, and the mode bit stays set, so software can see that the store is full.

A fetch port reads stored words for the execution side, using a valid/ready request and a valid/ready response. A request is taken only when `fetch_req_valid` and `fetch_req_ready` are both high. `fetch_req_ready` is low while programming mode is on. It is also low while a response is held and `fetch_rsp_ready` is low. A response stays valid and unchanged until the consumer raises `fetch_rsp_ready`. When parity checking is enabled, every accepted fetch compares the stored parity bits against its instruction bits. A mismatch marks that response and sets a sticky error flag.

Top module: `ucode_store_loader`

## Requirements
- R1: After reset the index register reads 0x00000000, the control register reads 0, `parity_err` and `fetch_rsp_valid` are 0, and `fetch_req_ready` is 1.
- R2: A host write to offset 0x000 sets programming mode from data bit 31 and sets the index from the low log2(DEPTH) data bits. A read of offset 0x000 returns the mode in bit 31 and the index in the low bits, with zeros elsewhere. Read data is valid (`csr_rvalid`) in the cycle after `csr_rd`.
- R3: In programming mode, a write to offset 0x008 stores {parity[1:0], wdata[7:0], low word} at the current index and advances the index by one. The low word is the last value written to offset 0x004.
- R4: When parity is enabled, stored bit 41 is the XOR of instruction bits 39:20 and stored bit 40 is the XOR of bits 19:0 (even parity). When parity is disabled, both stored bits are 0.
- R5: A commit at index DEPTH-1 leaves the index at 0 with the mode bit still set, so the index register reads 0x80000000.
- R6: A write to offset 0x004 alone changes neither the store nor the index.
- R7: A write to offset 0x008 while programming mode is off stores nothing and leaves the index unchanged.
- R8: A request accepted in cycle n gives `fetch_rsp_valid` in cycle n+1, with `fetch_rsp_word` equal to the 42-bit stored word at `fetch_req_addr`. While `fetch_rsp_valid` is high and `fetch_rsp_ready` is low, the response stays unchanged and `fetch_req_ready` is 0. `fetch_req_ready` is 0 during programming mode.
- R9: `parity_err` is set by an accepted fetch that fails either half check while parity is enabled. It stays set until reset.
- R10: Offset 0x018 bit 28 is the parity enable. A read of that offset returns only bit 28; all other bits read 0.
- R11: `fetch_rsp_perr` is 1 for a response whose word failed a parity check while parity was enabled at acceptance, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Host write strobe |
| csr_rd | input | 1 | Host read strobe |
| csr_addr | input | 12 | Host byte offset |
| csr_wdata | input | 32 | Host write data |
| csr_rdata | output | 32 | Host read data, registered |
| csr_rvalid | output | 1 | Read data valid |
| fetch_req_valid | input | 1 | Fetch request valid |
| fetch_req_ready | output | 1 | Fetch request ready |
| fetch_req_addr | input | AW | Fetch address |
| fetch_rsp_valid | output | 1 | Fetch response valid |
| fetch_rsp_ready | input | 1 | Fetch response ready |
| fetch_rsp_word | output | 42 | Stored word with parity bits |
| fetch_rsp_perr | output | 1 | Parity failure on this response |
| parity_err | output | 1 | Sticky parity error flag |

## Verification
The assertions assume that the host never asserts `csr_wr` and `csr_rd` for the same offset in one cycle. They also assume that fetches address only locations that were written earlier, so no stored word is unknown. The bench drives every strobe for exactly one cycle on the falling edge. It fetches only addresses it has programmed. It produces a parity failure only by storing a word while parity is disabled and then enabling checking. This keeps the store free of unknown words while still exercising the error path.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int INSN_W = 40;
  localparam int WORD_W = INSN_W + 2;
  localparam int HALF_W = INSN_W / 2;
  localparam int CSR_AW = 12;
  localparam int CSR_DW = 32;

  localparam logic [CSR_AW-1:0] OFF_INDEX = 12'h000;
  localparam logic [CSR_AW-1:0] OFF_LOW   = 12'h004;
  localparam logic [CSR_AW-1:0] OFF_HIGH  = 12'h008;
  localparam logic [CSR_AW-1:0] OFF_CTRL  = 12'h018;

  localparam int MODE_BIT   = 31;
  localparam int PAREN_BIT  = 28;

  // {odd-count of upper half, odd-count of lower half}
  function automatic logic [1:0] half_parity(input logic [INSN_W-1:0] insn);
    return {^insn[INSN_W-1:HALF_W], ^insn[HALF_W-1:0]};
  endfunction
endpackage

// File: rtl/ucs_csr.sv
module ucs_csr
  import ucs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [CSR_DW-1:0] csr_wdata,
  output logic [CSR_DW-1:0] csr_rdata,
  output logic              csr_rvalid,
  output logic              prog_mode,
  output logic              par_en,
  output logic              commit_we,
  output logic [AW-1:0]     commit_addr,
  output logic [WORD_W-1:0] commit_word
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic              wr_index, wr_low, wr_high, wr_ctrl;
  logic [AW-1:0]     index_q;
  logic [CSR_DW-1:0] low_q;
  logic [7:0]        high_q;
  logic [INSN_W-1:0] insn;
  logic [CSR_DW-1:0] rd_mux;

  assign wr_index = csr_wr && (csr_addr == OFF_INDEX);
  assign wr_low   = csr_wr && (csr_addr == OFF_LOW);
  assign wr_high  = csr_wr && (csr_addr == OFF_HIGH);
  assign wr_ctrl  = csr_wr && (csr_addr == OFF_CTRL);

  assign commit_we   = wr_high && prog_mode;
  assign commit_addr = index_q;
  assign insn        = {csr_wdata[7:0], low_q};
  assign commit_word = {(par_en ? half_parity(insn) : 2'b00), insn};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_mode <= 1'b0;
      index_q   <= '0;
      low_q     <= '0;
      high_q    <= '0;
      par_en    <= 1'b0;
    end else begin
      if (wr_index) begin
        prog_mode <= csr_wdata[MODE_BIT];
        index_q   <= csr_wdata[AW-1:0];
      end else if (commit_we) begin
        index_q <= (index_q == LAST) ? '0 : index_q + AW'(1);
      end
      if (wr_low)  low_q  <= csr_wdata;
      if (wr_high) high_q <= csr_wdata[7:0];
      if (wr_ctrl) par_en <= csr_wdata[PAREN_BIT];
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (csr_addr)
      OFF_INDEX: begin
        rd_mux[MODE_BIT] = prog_mode;
        rd_mux[AW-1:0]   = index_q;
      end
      OFF_LOW:   rd_mux = low_q;
      OFF_HIGH:  rd_mux[7:0] = high_q;
      OFF_CTRL:  rd_mux[PAREN_BIT] = par_en;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      csr_rvalid <= 1'b0;
      csr_rdata  <= '0;
    end else begin
      csr_rvalid <= csr_rd;
      if (csr_rd) csr_rdata <= rd_mux;
    end
  end

  assert_index_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && !wr_index && index_q != LAST) |=> (index_q == $past(index_q) + AW'(1)));
  assert_wrap_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && index_q == LAST) |=> (prog_mode && index_q == '0));
  assert_low_no_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_low && !wr_index) |=> $stable(index_q));
  assert_idle_high_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_high && !prog_mode && !wr_index) |=> ($stable(index_q) && !prog_mode));
endmodule

// File: rtl/ucs_store.sv
module ucs_store
  import ucs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ucs_fetch.sv
module ucs_fetch
  import ucs_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_mode,
  input  logic              par_en,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AW-1:0]     req_addr,
  output logic [AW-1:0]     rd_addr,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_word,
  output logic              rsp_perr,
  output logic              perr_flag
);
  logic accept, mismatch;

  assign rd_addr   = req_addr;
  assign req_ready = !prog_mode && (!rsp_valid || rsp_ready);
  assign accept    = req_valid && req_ready;
  assign mismatch  = par_en && (half_parity(rd_word[INSN_W-1:0]) != rd_word[WORD_W-1:INSN_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
      rsp_perr  <= 1'b0;
      perr_flag <= 1'b0;
    end else begin
      if (accept) begin
        rsp_valid <= 1'b1;
        rsp_word  <= rd_word;
        rsp_perr  <= mismatch;
      end else if (rsp_ready) begin
        rsp_valid <= 1'b0;
      end
      if (accept && mismatch) perr_flag <= 1'b1;
    end
  end

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word) && $stable(rsp_perr)));
  assert_no_fetch_in_prog_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> !req_ready);
  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perr_flag |=> perr_flag);
  assert_rsp_err_sets_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |-> perr_flag);
endmodule

// File: rtl/ucode_store_loader.sv
module ucode_store_loader
  import ucs_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr,
  input  logic              csr_rd,
  input  logic [11:0]       csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              csr_rvalid,
  input  logic              fetch_req_valid,
  output logic              fetch_req_ready,
  input  logic [AW-1:0]     fetch_req_addr,
  output logic              fetch_rsp_valid,
  input  logic              fetch_rsp_ready,
  output logic [41:0]       fetch_rsp_word,
  output logic              fetch_rsp_perr,
  output logic              parity_err
);
  logic              prog_mode, par_en, commit_we;
  logic [AW-1:0]     commit_addr, rd_addr;
  logic [WORD_W-1:0] commit_word, rd_word;

  ucs_csr #(.DEPTH(DEPTH), .AW(AW)) u_csr (
    .clk(clk), .rst_n(rst_n),
    .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid),
    .prog_mode(prog_mode), .par_en(par_en),
    .commit_we(commit_we), .commit_addr(commit_addr), .commit_word(commit_word)
  );

  ucs_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .we(commit_we), .waddr(commit_addr), .wdata(commit_word),
    .raddr(rd_addr), .rdata(rd_word)
  );

  ucs_fetch #(.AW(AW)) u_fetch (
    .clk(clk), .rst_n(rst_n), .prog_mode(prog_mode), .par_en(par_en),
    .req_valid(fetch_req_valid), .req_ready(fetch_req_ready), .req_addr(fetch_req_addr),
    .rd_addr(rd_addr), .rd_word(rd_word),
    .rsp_valid(fetch_rsp_valid), .rsp_ready(fetch_rsp_ready),
    .rsp_word(fetch_rsp_word), .rsp_perr(fetch_rsp_perr), .perr_flag(parity_err)
  );

  // R6: the store is written only by a high-word write in programming mode
  assert_commit_only_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit_we |-> (csr_wr && csr_addr == OFF_HIGH && prog_mode));
  assert_stored_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_we && par_en) |-> (commit_word[41] == ^commit_word[39:20] && commit_word[40] == ^commit_word[19:0]));
endmodule

// File: tb/tb_ucode_store_loader.sv
`timescale 1ns/1ps
module tb_ucode_store_loader;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam int NV = 6;
  localparam logic [39:0] VEC [NV] = '{
    40'h00_00000000, 40'hFF_FFFFFFFF, 40'h12_34567890,
    40'h80_00000001, 40'h00_00100000, 40'hA5_5A0F0F33
  };

  logic clk = 0, rst_n = 0;
  logic csr_wr = 0, csr_rd = 0;
  logic [11:0] csr_addr = 0;
  logic [31:0] csr_wdata = 0, csr_rdata;
  logic csr_rvalid;
  logic fetch_req_valid = 0, fetch_req_ready;
  logic [AW-1:0] fetch_req_addr = 0;
  logic fetch_rsp_valid, fetch_rsp_ready = 1;
  logic [41:0] fetch_rsp_word;
  logic fetch_rsp_perr, parity_err;

  int n_chk = 0, n_bad = 0;
  logic [31:0] rd_val;
  logic [41:0] got_w;
  logic got_p;

  always #2.5 clk = ~clk;

  ucode_store_loader #(.DEPTH(DEPTH)) dut (.*);

  function automatic logic [41:0] expect_word(input logic [39:0] i, input logic pe);
    logic [1:0] p;
    p = pe ? {^i[39:20], ^i[19:0]} : 2'b00;
    return {p, i};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); csr_wr = 1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk); csr_rd = 1; csr_addr = a;
    @(negedge clk); csr_rd = 0; rd_val = csr_rvalid ? csr_rdata : 32'hxxxxxxxx;
  endtask

  task automatic fetch(input logic [AW-1:0] a);
    @(negedge clk); fetch_req_valid = 1; fetch_req_addr = a; fetch_rsp_ready = 1;
    @(negedge clk); fetch_req_valid = 0;
    got_w = fetch_rsp_valid ? fetch_rsp_word : 'x; got_p = fetch_rsp_perr;
  endtask

  task automatic load(input logic [39:0] i);
    wr(12'h004, i[31:0]);
    wr(12'h008, {24'h0, i[39:32]});
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 ready", fetch_req_ready, 1);
    check("R1 rsp_valid", fetch_rsp_valid, 0);
    check("R1 parity_err", parity_err, 0);
    rd(12'h000); check("R1 index", rd_val, 0);
    rd(12'h018); check("R1 ctrl", rd_val, 0);
    // R10 parity enable bit only
    wr(12'h018, 32'hFFFFFFFF); rd(12'h018); check("R10 ctrl all ones", rd_val, 32'h10000000);
    // R2 enter programming at 0
    wr(12'h000, 32'h80000000); rd(12'h000); check("R2 index mode", rd_val, 32'h80000000);
    check("R8 ready low in prog", fetch_req_ready, 0);
    // R3 table of vectors
    for (int i = 0; i < NV; i++) begin
      wr(12'h004, VEC[i][31:0]);
      rd(12'h000); check("R6 low write no step", rd_val, 32'h80000000 | i);
      wr(12'h008, {24'h0, VEC[i][39:32]});
      rd(12'h000); check("R3 index step", rd_val, 32'h80000000 | (i + 1));
    end
    wr(12'h004, 32'hDEADBEEF);
    rd(12'h000); check("R6 stray low", rd_val, 32'h80000006);
    wr(12'h000, 32'h0);
    rd(12'h000); check("R2 end prog", rd_val, 0);
    for (int i = 0; i < NV; i++) begin
      fetch(AW'(i));
      check("R3/R4/R8 fetch word", got_w, expect_word(VEC[i], 1'b1));
      check("R11 no err", got_p, 0);
    end
    // R7 high write outside programming
    wr(12'h008, 32'h000000AB);
    rd(12'h000); check("R7 index unchanged", rd_val, 0);
    fetch(0); check("R7 store unchanged", got_w, expect_word(VEC[0], 1'b1));
    // R4 parity disabled stores zeros
    wr(12'h018, 32'h0);
    wr(12'h000, 32'h80000007);
    load(40'h00_00000001);
    wr(12'h000, 32'h0);
    fetch(7); check("R4 disabled parity bits", got_w, {2'b00, 40'h00_00000001});
    check("R11 disabled no err", got_p, 0);
    check("R9 flag clear", parity_err, 0);
    wr(12'h018, 32'h10000000);
    fetch(7); check("R11 err on bad word", got_p, 1);
    check("R9 flag set", parity_err, 1);
    fetch(0); check("R11 good after bad", got_p, 0);
    check("R9 flag sticky", parity_err, 1);
    // R5 wrap
    wr(12'h000, 32'h8000000E);
    load(40'h3C_00012345);
    load(40'h01_FFFF0000);
    rd(12'h000); check("R5 wrap keeps mode", rd_val, 32'h80000000);
    wr(12'h000, 32'h0);
    fetch(15); check("R5 last location", got_w, expect_word(40'h01_FFFF0000, 1'b1));
    // R8 back-pressure
    @(negedge clk); fetch_rsp_ready = 0; fetch_req_valid = 1; fetch_req_addr = 2;
    @(negedge clk); fetch_req_valid = 0;
    check("R8 rsp valid", fetch_rsp_valid, 1);
    check("R8 req blocked", fetch_req_ready, 0);
    got_w = fetch_rsp_word;
    @(negedge clk);
    check("R8 held valid", fetch_rsp_valid, 1);
    check("R8 held word", fetch_rsp_word, got_w);
    check("R8 word value", got_w, expect_word(VEC[2], 1'b1));
    fetch_rsp_ready = 1;
    @(negedge clk);
    check("R8 drained", fetch_rsp_valid, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule